// File: doc/BRIEF.md
# Kernel Dispatcher with Region Relocation

This block accepts kernel launch requests from a host and places each kernel onto a reconfigurable array that is split into column-group regions. Each request names how many neighbouring regions the kernel needs. Requests wait in a queue. The kernel at the head of the queue is placed as soon as a long enough run of free regions exists. Kernels are never reordered: if the head does not fit, every request behind it waits too.

Once a kernel is placed, the block takes that kernel's configuration stream from the host. It rewrites the region field of each address so that the kernel lands on the regions it was given, and forwards the word downstream. The host can therefore build one configuration image and reuse it in any placement. When the last word has gone through, the block pulses a start line for each region the kernel covers.

The kernel signals completion on its base region's done line. The block then raises that region's interrupt and holds it until the host acknowledges it. Only then are the kernel's regions returned to the free pool. Both configuration interfaces use valid/ready handshakes. A word moves only on a cycle where valid and ready are both high. A source must hold its word stable while valid is high and ready is low. The request interface follows the same rule.

Top module: `kdisp`

## Requirements
- R1: After reset the queue is empty (`q_count_o`=0, `req_ready_o`=1), no region is occupied, and `start_o`, `irq_o`, `cfg_out_valid_o` and `cfg_err_o` are all low.
- R2: Requests are placed strictly in arrival order. While the head request cannot be placed, no later request is placed, even if a later one would fit.
- R3: The queue holds QDEPTH (8) requests, and `q_count_o` shows how many are waiting. When the queue is full, `req_ready_o` is low and a presented request is not taken.
- R4: A request of length L (1..NREG) is placed on the lowest-numbered base b for which regions b..b+L-1 are all free. Its regions show as set in `occ_o` from the next cycle. If no such run exists, the head waits.
- R5: Configuration words are accepted only while a placed kernel is being configured. The output address equals the input address, except that its low 8 bits are replaced by base+offset, where offset is the input's low 8 bits. The upper 24 bits, the data and the last flag pass through unchanged. The output valid signal is combinational from the input, and the input ready signal follows `cfg_out_ready_i`.
- R6: A word whose offset is not below the kernel's length is taken from the input but not forwarded. Such a word sets `cfg_err_o`, which stays high until reset.
- R7: In the cycle after the last configuration word is accepted, `start_o` is high for exactly one cycle on every region of the kernel's span.
- R8: A pulse on `done_i[b]` while b is the base of a started kernel sets `irq_o[b]`. The interrupt stays high until `irq_ack_i[b]`. Done pulses on other bits are ignored.
- R9: A kernel's regions are cleared in `occ_o` on the edge where its pending interrupt is acknowledged, not when done arrives. Freed regions can be allocated from the following cycle.
- R10: An acknowledge on a bit with no pending interrupt has no effect on `occ_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Launch request valid |
| req_ready_o | output | 1 | Queue can take a request |
| req_len_i | input | LEN_W (4) | Number of contiguous regions requested |
| cfg_in_valid_i | input | 1 | Incoming configuration word valid |
| cfg_in_ready_o | output | 1 | Incoming configuration word taken |
| cfg_in_addr_i | input | ADDR_W (32) | Unrelocated configuration address |
| cfg_in_data_i | input | DATA_W (32) | Configuration data |
| cfg_in_last_i | input | 1 | Last word of this kernel |
| cfg_out_valid_o | output | 1 | Relocated word valid |
| cfg_out_ready_i | input | 1 | Downstream takes the word |
| cfg_out_addr_o | output | ADDR_W (32) | Relocated address |
| cfg_out_data_o | output | DATA_W (32) | Data, passed through |
| cfg_out_last_o | output | 1 | Last flag, passed through |
| start_o | output | NREG (8) | One-cycle start per region |
| done_i | input | NREG (8) | Completion pulse on a kernel's base region |
| irq_o | output | NREG (8) | Per-kernel interrupt, on the base region bit |
| irq_ack_i | input | NREG (8) | Interrupt acknowledge per base region |
| occ_o | output | NREG (8) | Region occupancy bitmap |
| q_count_o | output | CNT_W (4) | Requests waiting in the queue |
| cfg_err_o | output | 1 | Sticky out-of-span relocation error |

## Verification
Two events can land on the same edge: the acknowledge that frees one kernel, and the done pulse of a second resident kernel. The bench drives the acknowledge for base 0 and the done for base 1 in one cycle. It then expects interrupt bit 1 to be set, bit 0 to be cleared, and only region 0 to be released. A second overlap occurs when a new request is pushed on the same cycle the head is popped for placement, while the queue is filling behind a kernel under configuration. That case is judged by the exact queue count and by refusal at the depth limit.

// File: rtl/kdisp_pkg.sv
`timescale 1ns/1ps
package kdisp_pkg;
  // Dispatcher sequencing: waiting for a placeable head, or streaming its config.
  typedef enum logic {
    KD_IDLE = 1'b0,
    KD_CFG  = 1'b1
  } kd_state_e;
endpackage

// File: rtl/kdisp_queue.sv
`timescale 1ns/1ps
module kdisp_queue #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (int'(cnt) == DEPTH);
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
  assign dout_o  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_i) wptr <= nxt(wptr);
      if (pop_i)  rptr <= nxt(rptr);
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (pop_i && !push_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr] <= din_i;
  end
endmodule

// File: rtl/kdisp_fit.sv
`timescale 1ns/1ps
module kdisp_fit #(
  parameter int NREG = 8,
  localparam int LEN_W  = $clog2(NREG + 1),
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]   occ_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              found_o,
  output logic [RIDX_W-1:0] base_o,
  output logic [NREG-1:0]   mask_o
);
  logic [NREG-1:0] fit_vec;

  // One candidate checker per possible base region.
  for (genvar b = 0; b < NREG; b++) begin : g_cand
    logic ok;
    always_comb begin
      ok = (len_i != '0) && (b + int'(len_i) <= NREG);
      for (int i = 0; i < NREG; i++) begin
        if (i >= b && i < b + int'(len_i) && occ_i[i]) ok = 1'b0;
      end
    end
    assign fit_vec[b] = ok;
  end

  // Lowest-numbered candidate wins.
  always_comb begin
    found_o = 1'b0;
    base_o  = '0;
    for (int b = NREG - 1; b >= 0; b--) begin
      if (fit_vec[b]) begin
        found_o = 1'b1;
        base_o  = RIDX_W'(b);
      end
    end
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NREG; i++) begin
      mask_o[i] = found_o && (i >= int'(base_o)) && (i < int'(base_o) + int'(len_i));
    end
  end
endmodule

// File: rtl/kdisp_reloc.sv
`timescale 1ns/1ps
module kdisp_reloc #(
  parameter int NREG    = 8,
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 8,
  localparam int LEN_W  = $clog2(NREG + 1),
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [RIDX_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_span_o
);
  logic [FIELD_W-1:0] offs;
  logic [FIELD_W-1:0] moved;

  assign offs      = addr_i[FIELD_W-1:0];
  assign in_span_o = int'(offs) < int'(len_i);
  assign moved     = FIELD_W'(base_i) + offs;
  assign addr_o    = {addr_i[ADDR_W-1:FIELD_W], moved};
endmodule

// File: rtl/kdisp.sv
`timescale 1ns/1ps
module kdisp #(
  parameter int NREG    = 8,
  parameter int QDEPTH  = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  localparam int LEN_W  = $clog2(NREG + 1),
  localparam int CNT_W  = $clog2(QDEPTH + 1),
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              cfg_in_valid_i,
  output logic              cfg_in_ready_o,
  input  logic [ADDR_W-1:0] cfg_in_addr_i,
  input  logic [DATA_W-1:0] cfg_in_data_i,
  input  logic              cfg_in_last_i,
  output logic              cfg_out_valid_o,
  input  logic              cfg_out_ready_i,
  output logic [ADDR_W-1:0] cfg_out_addr_o,
  output logic [DATA_W-1:0] cfg_out_data_o,
  output logic              cfg_out_last_o,
  output logic [NREG-1:0]   start_o,
  input  logic [NREG-1:0]   done_i,
  output logic [NREG-1:0]   irq_o,
  input  logic [NREG-1:0]   irq_ack_i,
  output logic [NREG-1:0]   occ_o,
  output logic [CNT_W-1:0]  q_count_o,
  output logic              cfg_err_o
);
  import kdisp_pkg::*;

  kd_state_e        state;
  logic [NREG-1:0]  occ, run, irq, start_q;
  logic [LEN_W-1:0] len_tab [NREG];
  logic [RIDX_W-1:0] cur_base;
  logic [LEN_W-1:0] cur_len;
  logic [NREG-1:0]  cur_mask;
  logic             err_q;

  // Queue
  logic             q_full, q_empty, q_push, q_pop;
  logic [LEN_W-1:0] head_len;

  assign q_push      = req_valid_i && !q_full;
  assign req_ready_o = !q_full;

  kdisp_queue #(.W(LEN_W), .DEPTH(QDEPTH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (q_push),
    .din_i   (req_len_i),
    .pop_i   (q_pop),
    .dout_o  (head_len),
    .count_o (q_count_o),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  // Allocation against registered occupancy
  logic              fit_found;
  logic [RIDX_W-1:0] fit_base;
  logic [NREG-1:0]   fit_mask;
  logic              dispatch;

  kdisp_fit #(.NREG(NREG)) u_fit (
    .occ_i   (occ),
    .len_i   (head_len),
    .found_o (fit_found),
    .base_o  (fit_base),
    .mask_o  (fit_mask)
  );

  assign dispatch = (state == KD_IDLE) && !q_empty && fit_found;
  assign q_pop    = dispatch;

  // Relocation on the configuration stream
  logic in_span, in_cfg, word_acc, finish;

  kdisp_reloc #(.NREG(NREG), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_reloc (
    .addr_i    (cfg_in_addr_i),
    .base_i    (cur_base),
    .len_i     (cur_len),
    .addr_o    (cfg_out_addr_o),
    .in_span_o (in_span)
  );

  assign in_cfg          = (state == KD_CFG);
  assign cfg_out_valid_o = in_cfg && cfg_in_valid_i && in_span;
  assign cfg_in_ready_o  = in_cfg && (cfg_out_ready_i || !in_span);
  assign cfg_out_data_o  = cfg_in_data_i;
  assign cfg_out_last_o  = cfg_in_last_i;
  assign word_acc        = cfg_in_valid_i && cfg_in_ready_o;
  assign finish          = word_acc && cfg_in_last_i;

  // Completion and release
  logic [NREG-1:0] done_hit, ack_hit, free_mask;

  assign done_hit = done_i & run;
  assign ack_hit  = irq_ack_i & irq;

  always_comb begin
    free_mask = '0;
    for (int b = 0; b < NREG; b++) begin
      for (int i = 0; i < NREG; i++) begin
        if (ack_hit[b] && i >= b && i < b + int'(len_tab[b])) free_mask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= KD_IDLE;
      occ      <= '0;
      run      <= '0;
      irq      <= '0;
      start_q  <= '0;
      cur_base <= '0;
      cur_len  <= '0;
      cur_mask <= '0;
      err_q    <= 1'b0;
      for (int b = 0; b < NREG; b++) len_tab[b] <= '0;
    end else begin
      occ     <= (occ & ~free_mask) | (dispatch ? fit_mask : '0);
      run     <= (run & ~done_hit) | (finish ? (NREG'(1) << cur_base) : '0);
      irq     <= (irq & ~ack_hit) | done_hit;
      start_q <= finish ? cur_mask : '0;
      if (word_acc && !in_span) err_q <= 1'b1;
      if (dispatch) begin
        state             <= KD_CFG;
        cur_base          <= fit_base;
        cur_len           <= head_len;
        cur_mask          <= fit_mask;
        len_tab[fit_base] <= head_len;
      end else if (finish) begin
        state <= KD_IDLE;
      end
    end
  end

  assign occ_o     = occ;
  assign irq_o     = irq;
  assign start_o   = start_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/kdisp_chk.sv
`timescale 1ns/1ps
module kdisp_chk #(
  parameter int NREG    = 8,
  parameter int QDEPTH  = 8,
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 8,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              cfg_out_valid_o,
  input logic [ADDR_W-1:0] cfg_out_addr_o,
  input logic [NREG-1:0]   start_o,
  input logic [NREG-1:0]   irq_o,
  input logic [NREG-1:0]   irq_ack_i,
  input logic [NREG-1:0]   occ_o,
  input logic [CNT_W-1:0]  q_count_o,
  input logic              cfg_err_o
);
  // R3
  q_full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_count_o) == QDEPTH) |-> !req_ready_o);
  // R3
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count_o) <= QDEPTH);
  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |=> (start_o == '0));
  // R7
  start_in_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o & ~occ_o) == '0);
  // R9
  irq_in_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~occ_o) == '0);
  // R5
  reloc_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_valid_o |-> (int'(cfg_out_addr_o[FIELD_W-1:0]) < NREG &&
                         occ_o[cfg_out_addr_o[FIELD_W-1:0]]));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> cfg_err_o);
  for (genvar b = 0; b < NREG; b++) begin : g_irq
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[b] && !irq_ack_i[b]) |=> irq_o[b]);
  end
endmodule

bind kdisp kdisp_chk #(.NREG(NREG), .QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready_o     (req_ready_o),
  .cfg_out_valid_o (cfg_out_valid_o),
  .cfg_out_addr_o  (cfg_out_addr_o),
  .start_o         (start_o),
  .irq_o           (irq_o),
  .irq_ack_i       (irq_ack_i),
  .occ_o           (occ_o),
  .q_count_o       (q_count_o),
  .cfg_err_o       (cfg_err_o)
);

// File: tb/tb_kdisp.sv
`timescale 1ns/1ps
module tb_kdisp;
  localparam int NREG = 8, QDEPTH = 8, ADDR_W = 32, DATA_W = 32;
  localparam int LEN_W = 4, CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [LEN_W-1:0] req_len_i = '0;
  logic cfg_in_valid_i = 1'b0, cfg_in_ready_o, cfg_in_last_i = 1'b0;
  logic [ADDR_W-1:0] cfg_in_addr_i = '0, cfg_out_addr_o;
  logic [DATA_W-1:0] cfg_in_data_i = '0, cfg_out_data_o;
  logic cfg_out_valid_o, cfg_out_ready_i = 1'b1, cfg_out_last_o;
  logic [NREG-1:0] start_o, done_i = '0, irq_o, irq_ack_i = '0, occ_o;
  logic [CNT_W-1:0] q_count_o;
  logic cfg_err_o;

  always #10 clk = ~clk;

  kdisp dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [NREG-1:0] occ_m = '0;
  int len_m [NREG];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NREG-1:0] span(input int b, input int l);
    logic [NREG-1:0] m = '0;
    for (int i = 0; i < NREG; i++) if (i >= b && i < b + l) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int fit_m(input int l);
    for (int b = 0; b + l <= NREG; b++) if ((occ_m & span(b, l)) == '0) return b;
    return -1;
  endfunction

  task automatic push_req(input int l);
    req_len_i = LEN_W'(l);
    req_valid_i = 1'b1;
    #1;
    for (int g = 0; g < 1000 && !req_ready_o; g++) tick();
    tick();
    req_valid_i = 1'b0;
  endtask

  // Streams one kernel's config; base is predicted from the bench occupancy model.
  task automatic send_cfg(input int l, input int nwords, input bit bad_first);
    int b = fit_m(l);
    for (int w = 0; w < nwords; w++) begin
      int off = (bad_first && w == 0) ? l : int'($urandom % l);
      logic [ADDR_W-1:0] a = {24'($urandom), 8'(off)};
      logic [DATA_W-1:0] d = $urandom;
      cfg_in_addr_i = a;
      cfg_in_data_i = d;
      cfg_in_last_i = (w == nwords - 1);
      cfg_in_valid_i = 1'b1;
      #1;
      for (int g = 0; g < 1000 && !cfg_in_ready_o; g++) begin tick(); #1; end
      if (off < l) begin
        logic [ADDR_W-1:0] ea = {a[31:8], 8'(b + off)};
        check(cfg_out_valid_o && cfg_out_addr_o == ea && cfg_out_data_o == d &&
              cfg_out_last_o == (w == nwords - 1), "R5 relocated word", cfg_out_addr_o, ea);
      end else begin
        check(!cfg_out_valid_o && cfg_in_ready_o, "R6 out-of-span word dropped",
              cfg_out_valid_o, 0);
      end
      tick();
      if (off >= l) check(cfg_err_o == 1'b1, "R6 error flag set", cfg_err_o, 1);
    end
    cfg_in_valid_i = 1'b0;
    cfg_in_last_i = 1'b0;
    check(start_o == span(b, l), "R7 start pulse on span", start_o, span(b, l));
    check((occ_o & span(b, l)) == span(b, l), "R4 span occupied", occ_o, span(b, l));
    occ_m = occ_m | span(b, l);
    len_m[b] = l;
    tick();
    check(start_o == '0, "R7 start is one cycle", start_o, 0);
  endtask

  task automatic free_k(input int b);
    logic [NREG-1:0] m = span(b, len_m[b]);
    done_i = NREG'(1) << b;
    tick();
    done_i = '0;
    check(irq_o[b] == 1'b1, "R8 irq raised on done", irq_o, NREG'(1) << b);
    check((occ_o & m) == m, "R9 still held before ack", occ_o, m);
    irq_ack_i = NREG'(1) << b;
    tick();
    irq_ack_i = '0;
    check(irq_o[b] == 1'b0, "R8 irq cleared by ack", irq_o[b], 0);
    check((occ_o & m) == '0, "R9 freed after ack", occ_o & m, 0);
    occ_m = occ_m & ~m;
    len_m[b] = 0;
  endtask

  task automatic free_all();
    for (int b = 0; b < NREG; b++) if (len_m[b] > 0) free_k(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NREG; i++) len_m[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    check(q_count_o == 0 && req_ready_o, "R1 queue empty", q_count_o, 0);
    check(occ_o == 0 && irq_o == 0 && start_o == 0, "R1 regions free", occ_o, 0);
    check(!cfg_out_valid_o && !cfg_err_o, "R1 stream idle", cfg_err_o, 0);
    rst_n = 1'b1;
    tick();

    // R3 fill: one is popped for configuration, eight remain
    for (int k = 0; k < 9; k++) push_req(1);
    check(q_count_o == CNT_W'(8), "R3 queue at depth", q_count_o, 8);
    check(!req_ready_o, "R3 ready low when full", req_ready_o, 0);
    req_len_i = 4'd1;
    req_valid_i = 1'b1;
    repeat (3) tick();
    req_valid_i = 1'b0;
    check(q_count_o == CNT_W'(8), "R3 full queue refuses", q_count_o, 8);

    // R4 eight single-region kernels fill regions 0..7 in order
    for (int k = 0; k < 8; k++) send_cfg(1, 1 + (k % 3), 1'b0);
    repeat (3) tick();
    check(occ_o == 8'hFF && q_count_o == CNT_W'(1), "R4 head stalls with no space", q_count_o, 1);
    check(!cfg_in_ready_o, "R4 no config while stalled", cfg_in_ready_o, 0);

    // R10 acknowledge without a pending interrupt
    irq_ack_i = 8'h20;
    tick();
    irq_ack_i = '0;
    check(occ_o == 8'hFF && irq_o == 0, "R10 stray ack ignored", occ_o, 8'hFF);

    // R9 freeing region 3 lets the ninth kernel in; R6 out-of-span word
    free_k(3);
    send_cfg(1, 2, 1'b1);
    free_all();
    done_i = 8'hFF;
    tick();
    done_i = '0;
    check(irq_o == 0, "R8 done on idle regions ignored", irq_o, 0);

    // R2 head of line blocks a later request that would fit
    push_req(6);
    send_cfg(6, 2, 1'b0);
    push_req(4);
    push_req(1);
    repeat (4) tick();
    check(q_count_o == CNT_W'(2) && occ_o == 8'h3F, "R2 no bypass of stalled head", q_count_o, 2);
    free_k(0);
    send_cfg(4, 2, 1'b0);
    send_cfg(1, 1, 1'b0);
    free_all();

    // Acknowledge of one kernel and done of another on the same edge
    push_req(1); send_cfg(1, 1, 1'b0);
    push_req(1); send_cfg(1, 1, 1'b0);
    done_i = 8'h01;
    tick();
    done_i = 8'h02;
    irq_ack_i = 8'h01;
    tick();
    done_i = '0;
    irq_ack_i = '0;
    check(irq_o == 8'h02, "R8 same-edge done and ack", irq_o, 8'h02);
    check(occ_o == 8'h02, "R9 only acked kernel freed", occ_o, 8'h02);
    occ_m = 8'h02; len_m[0] = 0;
    irq_ack_i = 8'h02;
    tick();
    irq_ack_i = '0;
    check(occ_o == 0, "R9 second kernel freed", occ_o, 0);
    occ_m = '0; len_m[1] = 0;

    // Random lengths and word counts, with random releases
    for (int it = 0; it < 40; it++) begin
      int l = int'($urandom % NREG) + 1;
      while (fit_m(l) < 0) begin
        for (int b = 0; b < NREG; b++) if (len_m[b] > 0) begin free_k(b); break; end
      end
      push_req(l);
      send_cfg(l, int'($urandom % 3) + 1, 1'b0);
      if ($urandom % 3 == 0) begin
        int s = int'($urandom % NREG);
        for (int j = 0; j < NREG; j++) begin
          int b = (s + j) % NREG;
          if (len_m[b] > 0) begin free_k(b); break; end
        end
      end
    end
    free_all();
    check(occ_o == 0 && q_count_o == 0, "R9 all regions released", occ_o, 0);
    check(cfg_err_o == 1'b1, "R6 error flag sticky", cfg_err_o, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule